// File: doc/BRIEF.md
# Loadable Synchronous Binary Counter with Dual Enables

This block is a four-bit (parameterizable) synchronous up counter. On each rising clock edge it either clears to zero, copies a parallel data word into the count, advances by one, or holds its value. Clear takes priority over load, and load takes priority over counting. The counter advances only when both of its enables are high.

A carry output goes high when the count sits at its all-ones value and the chain enable is high. A following stage can use it as that stage's chain enable, so several units can be joined into a wider synchronous counter. Every state change takes place at the clock edge. The asynchronous active-low reset sets the count to zero.

Top module: `sync_load_counter`

## Requirements
- R1: While rst_n is low, the count reads 0.
- R2: With sclr high at a rising edge, the count becomes 0 after that edge, whatever the other inputs are.
- R3: With sclr low and load high at a rising edge, the count becomes load_val after that edge, whatever the enables are.
- R4: With sclr and load low and both en_p and en_t high, the count becomes (count+1) mod 2^W after the edge, where W is the width (default 4).
- R5: With sclr and load low and either enable low, the count keeps its value.
- R6: From the all-ones state, a count step wraps the count to 0.
- R7: carry_out equals en_t AND (count is all ones). It is combinational, and en_p has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclr | input | 1 | Synchronous clear, active high |
| load | input | 1 | Synchronous parallel load, active high |
| load_val | input | WIDTH | Data for parallel load |
| en_p | input | 1 | Count enable, not used by the carry |
| en_t | input | 1 | Count enable, also gates the carry |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when en_t is high and count is all ones |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge and holds steady around it. The bench changes inputs only on falling edges and never drives X or Z. The checks tie the count after an edge to the controls sampled at that edge, so they treat inputs between edges as irrelevant. The bench holds clear and load low for most cycles so that long count runs reach the wrap.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } slc_op_e;
endpackage

// File: rtl/slc_ctrl.sv
module slc_ctrl
  import slc_pkg::*;
(
  input  logic    sclr,
  input  logic    load,
  input  logic    en_p,
  input  logic    en_t,
  output slc_op_e op
);
  always_comb begin
    if (sclr)             op = OP_CLEAR;
    else if (load)        op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                  op = OP_HOLD;
  end
endmodule

// File: rtl/slc_next.sv
module slc_next
  import slc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  slc_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);
  always_comb begin
    upd = 1'b1;
    nxt = cur;
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = load_val;
      OP_COUNT: nxt = cur + WIDTH'(1);
      default:  upd = 1'b0;
    endcase
  end
endmodule

// File: rtl/sync_load_counter.sv
module sync_load_counter
  import slc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclr,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  slc_op_e          op;
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  slc_ctrl u_ctrl (
    .sclr(sclr), .load(load), .en_p(en_p), .en_t(en_t), .op(op)
  );

  slc_next #(.WIDTH(WIDTH)) u_next (
    .op(op), .cur(cnt_q), .load_val(load_val), .nxt(cnt_d), .upd(cnt_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count     = cnt_q;
  assign carry_out = en_t && (cnt_q == ALL_ONES);
endmodule

// File: rtl/sync_load_counter_chk.sv
module sync_load_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclr,
  input logic             load,
  input logic [WIDTH-1:0] load_val,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);
  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (count == '0); // R1
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sclr |=> count == '0); // R2
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && load) |=> count == $past(load_val)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && !load && en_p && en_t) |=> count == WIDTH'($past(count) + 1'b1)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && !load && !(en_p && en_t)) |=> $stable(count)); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && !load && en_p && en_t && (&count)) |=> count == '0); // R6
  AST_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out == (en_t && (&count))); // R7
endmodule

bind sync_load_counter sync_load_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sync_load_counter_bench.sv
module sync_load_counter_bench;
  localparam int W = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclr = 1'b0, load = 1'b0, en_p = 1'b0, en_t = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic carry_out;
  int errors = 0, checks = 0;
  logic [W-1:0] model = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_load_counter #(.WIDTH(W)) u_sync_load_counter (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .load(load), .load_val(load_val),
    .en_p(en_p), .en_t(en_t), .count(count), .carry_out(carry_out)
  );

  function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic c, logic l,
                                            logic [W-1:0] d, logic p, logic t);
    if (c) return '0;
    if (l) return d;
    if (p && t) return cur + 1'b1;
    return cur;
  endfunction

  function automatic logic exp_carry(logic [W-1:0] cur, logic t);
    return t && (cur == {W{1'b1}});
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on negedge, then check after the posedge
  task automatic step(string req, logic c, logic l, logic [W-1:0] d, logic p, logic t);
    @(negedge clk);
    sclr = c; load = l; load_val = d; en_p = p; en_t = t;
    #0;
    #1 chk("R7 carry", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, exp_carry(model, t)});
    model = next_val(model, c, l, d, p, t);
    @(posedge clk); #1;
    chk(req, count, model);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    chk("R1 reset", count, '0);
    @(negedge clk); rst_n = 1'b1;
    step("R3 load", 0, 1, 4'hA, 0, 0);
    step("R2 clear", 1, 1, 4'h5, 1, 1);
    step("R3 load over count", 0, 1, 4'hD, 1, 1);
    for (int i = 0; i < 5; i++) step("R4/R6 count wrap", 0, 0, 4'h0, 1, 1);
    step("R5 hold p low", 0, 0, 4'h7, 0, 1);
    step("R5 hold t low", 0, 0, 4'h7, 1, 0);
    step("R3 load ones", 0, 1, 4'hF, 0, 0);
    step("R7 hold at ones p low", 0, 0, 4'h0, 0, 1);
    step("R7 hold at ones t low", 0, 0, 4'h0, 1, 0);
    step("R6 wrap", 0, 0, 4'h3, 1, 1);
    for (int i = 0; i < 400; i++) begin
      automatic logic c = ($urandom % 16) == 0;
      automatic logic l = ($urandom % 10) == 0;
      automatic logic [W-1:0] d = W'($urandom);
      automatic logic p = ($urandom % 4) != 0;
      automatic logic t = ($urandom % 4) != 0;
      step("R2/R3/R4/R5 random", c, l, d, p, t);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule